// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block carries a CPU core through the steps that follow acceptance of an interrupt. It takes a maskable request gated by the first enable flag, or an active-low nonmaskable request that needs no enable. It saves a return frame on the long stack, one byte per cycle. Narrow mode saves a two-byte return address and wide mode saves the full three-byte address. A marker byte that records the interrupted mode is written after the address bytes.

For a maskable request, the handler address is read as two bytes from a vector table. The table address is built from an 8-bit page register (high byte) and the byte the peripheral supplied (low byte). For a nonmaskable request the vector read is skipped and a fixed handler address, set by a parameter, is used instead.

The core loads its registers every cycle from the next-state outputs. These outputs pass the core's current values through unchanged. In the one cycle that `done` is high, they carry the entry results: cleared enable flags, wide mode set, the new program counter and the moved stack pointer.

Top module: `irq_entry_seq`

## Requirements
- R1: A maskable request is accepted only when the block is idle, `irq_req` is 1 and `ief1_in` is 1. With `ief1_in` at 0 the request is ignored: `busy`, `st_we` and `rd_en` all stay 0.
- R2: A low level on `nmi_n` in an idle cycle is accepted whatever `ief1_in` is. When both requests are present, the nonmaskable one wins.
- R3: Each stack write goes to the stack pointer minus one, and the pointer then moves down by one. At `done`, `sp_nxt` equals `sp_in` captured at acceptance minus the frame length.
- R4: With `mode_in` = 0 at acceptance, the frame is PC[15:8], then PC[7:0], then the marker 00h: three writes in that order.
- R5: With `mode_in` = 1 at acceptance, the frame is PC[23:16], PC[15:8], PC[7:0], then the marker 01h: four writes in that order.
- R6: For a maskable entry, two reads follow the frame. The first is at {00h, page, vector} and the second at that address plus one (a 24-bit add). `rd_data` is valid one cycle after each read. The first byte read is the handler's low byte and the second its high byte.
- R7: In the `done` cycle, `pc_nxt` = {00h, handler[15:0]}, `mode_nxt` = 1, and `ief1_nxt` = `ief2_nxt` = 0.
- R8: A nonmaskable entry makes no reads and uses the handler address given by parameter `NMI_HANDLER`.
- R9: `busy` is 1 from the cycle after acceptance through the `done` cycle. `done` lasts one cycle. Requests and changes on `irq_vec` or `page_reg` while busy have no effect.
- R10: In every cycle without `done`, `pc_nxt`, `sp_nxt`, `mode_nxt`, `ief1_nxt` and `ief2_nxt` equal the corresponding inputs.
- R11: Let F be the frame length. `done` arrives F+4 cycles after the acceptance edge for a maskable entry, and F+1 cycles after it for a nonmaskable entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_n | input | 1 | Nonmaskable request, active low |
| irq_vec | input | 8 | Vector byte from the peripheral |
| page_reg | input | 8 | Interrupt page register |
| ief1_in | input | 1 | Current first enable flag |
| ief2_in | input | 1 | Current second enable flag |
| mode_in | input | 1 | Current mode bit (1 = wide) |
| pc_in | input | 24 | Current program counter |
| sp_in | input | 24 | Current long stack pointer |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | Single-cycle completion strobe |
| st_we | output | 1 | Stack byte write enable |
| st_addr | output | 24 | Stack write address |
| st_data | output | 8 | Stack write data |
| rd_en | output | 1 | Vector table read enable |
| rd_addr | output | 24 | Vector table read address |
| rd_data | input | 8 | Read data, one cycle after `rd_en` |
| pc_nxt | output | 24 | Next program counter |
| sp_nxt | output | 24 | Next long stack pointer |
| mode_nxt | output | 1 | Next mode bit |
| ief1_nxt | output | 1 | Next first enable flag |
| ief2_nxt | output | 1 | Next second enable flag |

## Verification
The assertions assume that the surrounding core loads its registers from the next-state outputs, so `pc_in` and `sp_in` are the values it wants saved when a request is accepted. They also assume that the memory answers a read in exactly the cycle after `rd_en`.

The bench models that memory as a registered lookup of a computed byte pattern, so the read latency always holds. It drives requests at the falling edge and holds the inputs for one acceptance edge. Its stimulus covers:
- deliberately disturbed vector, page and request inputs while busy;
- a stack pointer that wraps below zero;
- a vector byte of FFh, which makes the second read carry into the page byte.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH,
      ST_RD_LO,
      ST_RD_HI,
      ST_RD_WAIT,
      ST_FIN
   } seq_state_t;
endpackage

// File: rtl/irq_entry_arb.sv
module irq_entry_arb (
   input  logic idle,
   input  logic nmi_n,
   input  logic irq_req,
   input  logic ief1,
   output logic take,
   output logic take_nmi
);
   // nonmaskable wins and ignores the enable flag
   assign take_nmi = idle & ~nmi_n;
   assign take     = idle & (~nmi_n | (irq_req & ief1));
endmodule

// File: rtl/irq_entry_frame.sv
module irq_entry_frame #(
   parameter int BYTE_W       = 8,
   parameter int PC_BYTES     = 3,
   parameter int NARROW_BYTES = 2,
   parameter int IDX_W        = 3
) (
   input  logic                       wide,
   input  logic [PC_BYTES*BYTE_W-1:0] pc,
   input  logic [IDX_W-1:0]           idx,
   output logic [BYTE_W-1:0]          data,
   output logic                       last
);
   logic [BYTE_W-1:0] pc_b [PC_BYTES];
   logic [IDX_W-1:0]  nbytes;
   logic [IDX_W-1:0]  sel;

   for (genvar g = 0; g < PC_BYTES; g++) begin : g_split
      assign pc_b[g] = pc[g*BYTE_W +: BYTE_W];
   end

   assign nbytes = wide ? IDX_W'(PC_BYTES) : IDX_W'(NARROW_BYTES);
   assign sel    = nbytes - IDX_W'(1) - idx;
   assign last   = (idx == nbytes);

   always_comb begin
      data = {{(BYTE_W-1){1'b0}}, wide};
      if (idx < nbytes) begin
         for (int i = 0; i < PC_BYTES; i++) begin
            if (sel == IDX_W'(i)) data = pc_b[i];
         end
      end
   end
endmodule

// File: rtl/irq_entry_sp.sv
module irq_entry_sp #(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              dec,
   output logic [ADDR_W-1:0] sp,
   output logic [ADDR_W-1:0] wr_addr
);
   always_ff @(posedge clk) begin
      if (!rst_n)    sp <= '0;
      else if (load) sp <= load_val;
      else if (dec)  sp <= sp - ADDR_W'(1);
   end
   assign wr_addr = sp - ADDR_W'(1);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_entry_pkg::*;
#(
   parameter int          ADDR_W      = 24,
   parameter int          BYTE_W      = 8,
   parameter int unsigned NMI_HANDLER = 32'h0066
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic              nmi_n,
   input  logic [BYTE_W-1:0] irq_vec,
   input  logic [BYTE_W-1:0] page_reg,
   input  logic              ief1_in,
   input  logic              ief2_in,
   input  logic              mode_in,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [ADDR_W-1:0] sp_in,
   output logic              busy,
   output logic              done,
   output logic              st_we,
   output logic [ADDR_W-1:0] st_addr,
   output logic [BYTE_W-1:0] st_data,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [ADDR_W-1:0] pc_nxt,
   output logic [ADDR_W-1:0] sp_nxt,
   output logic              mode_nxt,
   output logic              ief1_nxt,
   output logic              ief2_nxt
);
   localparam int PC_BYTES     = ADDR_W / BYTE_W;
   localparam int H_W          = 2 * BYTE_W;
   localparam int NARROW_BYTES = H_W / BYTE_W;
   localparam int PAD_W        = ADDR_W - H_W;
   localparam int IDX_W        = $clog2(PC_BYTES + 2);

   if ((ADDR_W % BYTE_W) != 0 || PC_BYTES < 3) begin : g_bad_cfg
      $error("irq_entry_seq: ADDR_W must be a multiple of BYTE_W, at least three bytes");
   end

   seq_state_t          state;
   logic [IDX_W-1:0]    idx;
   logic                wide_q;
   logic                nmi_q;
   logic [ADDR_W-1:0]   pc_q;
   logic [ADDR_W-1:0]   vaddr_q;
   logic [H_W-1:0]      handler_q;
   logic                take, take_nmi, last;
   logic [ADDR_W-1:0]   sp_cur;

   irq_entry_arb u_arb (
      .idle     (state == ST_IDLE),
      .nmi_n    (nmi_n),
      .irq_req  (irq_req),
      .ief1     (ief1_in),
      .take     (take),
      .take_nmi (take_nmi)
   );

   irq_entry_frame #(
      .BYTE_W       (BYTE_W),
      .PC_BYTES     (PC_BYTES),
      .NARROW_BYTES (NARROW_BYTES),
      .IDX_W        (IDX_W)
   ) u_frame (
      .wide (wide_q),
      .pc   (pc_q),
      .idx  (idx),
      .data (st_data),
      .last (last)
   );

   irq_entry_sp #(.ADDR_W(ADDR_W)) u_sp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (take),
      .load_val (sp_in),
      .dec      (st_we),
      .sp       (sp_cur),
      .wr_addr  (st_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         idx       <= '0;
         wide_q    <= 1'b0;
         nmi_q     <= 1'b0;
         pc_q      <= '0;
         vaddr_q   <= '0;
         handler_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (take) begin
               state   <= ST_PUSH;
               idx     <= '0;
               wide_q  <= mode_in;
               nmi_q   <= take_nmi;
               pc_q    <= pc_in;
               vaddr_q <= {{PAD_W{1'b0}}, page_reg, irq_vec};
            end
            ST_PUSH: begin
               idx <= idx + IDX_W'(1);
               if (last) begin
                  if (nmi_q) begin
                     state     <= ST_FIN;
                     handler_q <= H_W'(NMI_HANDLER);
                  end else begin
                     state <= ST_RD_LO;
                  end
               end
            end
            ST_RD_LO: state <= ST_RD_HI;
            ST_RD_HI: begin
               handler_q[BYTE_W-1:0] <= rd_data;
               state <= ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
               handler_q[H_W-1:BYTE_W] <= rd_data;
               state <= ST_FIN;
            end
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state != ST_IDLE);
   assign done    = (state == ST_FIN);
   assign st_we   = (state == ST_PUSH);
   assign rd_en   = (state == ST_RD_LO) | (state == ST_RD_HI);
   assign rd_addr = (state == ST_RD_HI) ? vaddr_q + ADDR_W'(1) : vaddr_q;

   assign pc_nxt   = done ? {{PAD_W{1'b0}}, handler_q} : pc_in;
   assign sp_nxt   = done ? sp_cur : sp_in;
   assign mode_nxt = done | mode_in;
   assign ief1_nxt = ~done & ief1_in;
   assign ief2_nxt = ~done & ief2_in;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
   parameter int ADDR_W = 24,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_req,
   input logic              nmi_n,
   input logic              ief1_in,
   input logic              ief2_in,
   input logic              mode_in,
   input logic [ADDR_W-1:0] pc_in,
   input logic [ADDR_W-1:0] sp_in,
   input logic              busy,
   input logic              done,
   input logic              st_we,
   input logic [ADDR_W-1:0] st_addr,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [ADDR_W-1:0] pc_nxt,
   input logic [ADDR_W-1:0] sp_nxt,
   input logic              mode_nxt,
   input logic              ief1_nxt,
   input logic              ief2_nxt
);
   a_r1_no_enable_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && nmi_n && !(irq_req && ief1_in)) |=> !busy);

   a_r2_nmi_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !nmi_n) |=> (busy && st_we));

   a_r3_predecrement: assert property (@(posedge clk) disable iff (!rst_n)
      (st_we && $past(st_we)) |-> (st_addr == $past(st_addr) - ADDR_W'(1)));

   a_r6_read_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !$past(rd_en)) |=> (rd_en && rd_addr == $past(rd_addr) + ADDR_W'(1)));

   a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_we && rd_en));

   a_r7_exit_state: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (mode_nxt && !ief1_nxt && !ief2_nxt &&
                pc_nxt[ADDR_W-1:2*BYTE_W] == '0));

   a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   a_r10_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (pc_nxt == pc_in && sp_nxt == sp_in && mode_nxt == mode_in &&
                 ief1_nxt == ief1_in && ief2_nxt == ief2_in));
endmodule

bind irq_entry_seq irq_entry_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_n(nmi_n),
   .ief1_in(ief1_in), .ief2_in(ief2_in), .mode_in(mode_in),
   .pc_in(pc_in), .sp_in(sp_in), .busy(busy), .done(done),
   .st_we(st_we), .st_addr(st_addr), .rd_en(rd_en), .rd_addr(rd_addr),
   .pc_nxt(pc_nxt), .sp_nxt(sp_nxt), .mode_nxt(mode_nxt),
   .ief1_nxt(ief1_nxt), .ief2_nxt(ief2_nxt)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
   localparam int unsigned NMI_H = 32'h0066;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0, nmi_n = 1'b1;
   logic [7:0]  irq_vec = '0, page_reg = '0;
   logic        ief1_in = 1'b0, ief2_in = 1'b0, mode_in = 1'b0;
   logic [23:0] pc_in = '0, sp_in = '0;
   logic        busy, done, st_we, rd_en, mode_nxt, ief1_nxt, ief2_nxt;
   logic [23:0] st_addr, rd_addr, pc_nxt, sp_nxt;
   logic [7:0]  st_data;
   logic [7:0]  rd_data = '0;

   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   irq_entry_seq #(.NMI_HANDLER(NMI_H)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_n(nmi_n),
      .irq_vec(irq_vec), .page_reg(page_reg), .ief1_in(ief1_in),
      .ief2_in(ief2_in), .mode_in(mode_in), .pc_in(pc_in), .sp_in(sp_in),
      .busy(busy), .done(done), .st_we(st_we), .st_addr(st_addr),
      .st_data(st_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .pc_nxt(pc_nxt), .sp_nxt(sp_nxt), .mode_nxt(mode_nxt),
      .ief1_nxt(ief1_nxt), .ief2_nxt(ief2_nxt)
   );

   function automatic logic [7:0] memf(input logic [23:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
   endfunction

   always @(posedge clk) rd_data <= rd_en ? memf(rd_addr) : 8'h00;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_entry(input bit use_nmi, input bit use_irq, input bit mode,
                            input logic [23:0] pc, input logic [23:0] sp,
                            input logic [7:0] vec, input logic [7:0] page,
                            input bit ief1, input bit noise);
      logic [7:0]  exp_b [4];
      logic [23:0] va;
      logic [15:0] hexp;
      int flen, wcnt, rcnt, cyc;
      bit seen;
      flen = mode ? 4 : 3;
      if (mode) begin
         exp_b[0] = pc[23:16]; exp_b[1] = pc[15:8]; exp_b[2] = pc[7:0]; exp_b[3] = 8'h01;
      end else begin
         exp_b[0] = pc[15:8]; exp_b[1] = pc[7:0]; exp_b[2] = 8'h00; exp_b[3] = 8'h00;
      end
      va   = {8'h00, page, vec};
      hexp = use_nmi ? NMI_H[15:0] : {memf(va + 24'd1), memf(va)};
      @(negedge clk);
      irq_req = use_irq; nmi_n = ~use_nmi; mode_in = mode; pc_in = pc;
      sp_in = sp; irq_vec = vec; page_reg = page; ief1_in = ief1; ief2_in = 1'b1;
      @(negedge clk);
      if (noise) begin
         irq_vec = ~vec; page_reg = ~page; pc_in = ~pc; sp_in = ~sp;
      end else begin
         irq_req = 1'b0; nmi_n = 1'b1;
      end
      wcnt = 0; rcnt = 0; seen = 0;
      for (cyc = 1; cyc < 20; cyc++) begin
         chk(busy == 1'b1, "R9", "busy during entry", busy, 1);
         if (st_we) begin
            chk(st_addr == sp - 24'(wcnt + 1), "R3", "push address", st_addr, sp - 24'(wcnt + 1));
            if (wcnt < 4)
               chk(st_data == exp_b[wcnt], mode ? "R5" : "R4", "frame byte", st_data, exp_b[wcnt]);
            wcnt++;
         end
         if (rd_en) begin
            chk(rd_addr == va + 24'(rcnt), "R6", "vector read address", rd_addr, va + 24'(rcnt));
            rcnt++;
         end
         if (done) begin
            seen = 1;
            chk(pc_nxt == {8'h00, hexp}, use_nmi ? "R8" : "R7", "handler pc", pc_nxt, {8'h00, hexp});
            chk(mode_nxt == 1'b1 && ief1_nxt == 1'b0 && ief2_nxt == 1'b0, "R7", "flags/mode",
                {mode_nxt, ief1_nxt, ief2_nxt}, 3'b100);
            chk(sp_nxt == sp - 24'(flen), "R3", "final sp", sp_nxt, sp - 24'(flen));
            chk(cyc == (use_nmi ? flen + 1 : flen + 4), "R11", "latency", cyc,
                use_nmi ? flen + 1 : flen + 4);
            break;
         end
         @(negedge clk);
      end
      chk(seen, "R9", "done seen", seen, 1);
      chk(wcnt == flen, mode ? "R5" : "R4", "frame length", wcnt, flen);
      chk(rcnt == (use_nmi ? 0 : 2), use_nmi ? "R8" : "R6", "read count", rcnt, use_nmi ? 0 : 2);
      irq_req = 1'b0; nmi_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !st_we, "R9", "idle after done", {busy, done, st_we}, 0);
   endtask

   initial begin
      #800000;
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] r;
      r = $urandom(32'd7);
      repeat (3) @(negedge clk);
      chk(!busy && !done && !st_we && !rd_en, "R9", "reset state", {busy, done, st_we, rd_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      pc_in = 24'h123456; sp_in = 24'h00ABCD; mode_in = 0; ief1_in = 1; ief2_in = 0;
      #1;
      chk(pc_nxt == pc_in && sp_nxt == sp_in && mode_nxt == 0 && ief1_nxt == 1 && ief2_nxt == 0,
          "R10", "idle pass-through", pc_nxt, pc_in);
      // R1: enable flag low blocks a maskable request
      irq_req = 1; ief1_in = 0;
      repeat (3) begin
         @(negedge clk);
         chk(!busy && !st_we && !rd_en, "R1", "masked request ignored", {busy, st_we, rd_en}, 0);
      end
      irq_req = 0;
      run_entry(0, 1, 0, 24'h3C1234, 24'h001000, 8'h40, 8'h12, 1, 0);   // R4 narrow
      run_entry(0, 1, 1, 24'h9A7788, 24'h020000, 8'h10, 8'h80, 1, 0);   // R5 wide
      run_entry(1, 0, 0, 24'h00BEEF, 24'h000500, 8'h00, 8'h00, 0, 0);   // R2 nmi, ief1 low
      run_entry(1, 1, 1, 24'h5511AA, 24'h000300, 8'h22, 8'h33, 1, 0);   // R2 priority
      run_entry(0, 1, 1, 24'hFEDCBA, 24'h000002, 8'hFF, 8'h7E, 1, 0);   // R3 wrap, R6 carry
      run_entry(0, 1, 0, 24'h0F0F0F, 24'h004000, 8'h08, 8'h09, 1, 1);   // R9 noise while busy
      for (int k = 0; k < 40; k++) begin
         bit nm;
         nm = ($urandom % 4) == 0;
         run_entry(nm, !nm, 1'($urandom), 24'($urandom), 24'($urandom), 8'($urandom),
                   8'($urandom), 1'b1, 1'($urandom));
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule